// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a host processor three 8-bit general-purpose ports, A, B and C, behind a small register interface. The host reaches them over an 8-bit data bus using an active-low chip select, active-low read and write strobes and two register-select bits. Port C is managed as two 4-bit halves whose directions are chosen separately, so the 24 lines can serve as three byte ports, or as two byte ports plus two nibble ports. Pads are not inside the block. Each port line comes out as a separate input value, output value and output enable, and the chip-level pad ring combines them.

A write to the control address does one of two things, depending on its top bit. A mode word (top bit 1) sets the directions of the four port sections in basic input/output mode. A single-bit command (top bit 0) sets or clears one port C latch bit and leaves the directions untouched. Handshake and bidirectional modes are not built. A mode word that asks for either of them is ignored as a whole.

Writes are level-sensitive to the system clock: a register is updated on every rising clock edge at which chip select and the write strobe are both low. Reads are combinational. Input pins reach the read data without being latched, so any synchronisation of off-chip inputs belongs to the surrounding logic.

Top module: `ppi_port_top`

## Requirements
- R1: Register select `addr` picks port A (00), port B (01), port C (10) or control (11). While `cs_n` is high, no write has any effect and `dout_oe` stays low.
- R2: While `rst` is high, and after it is released, every output enable is 0, every output latch is 0 and the control register reads 0x9B: a mode word with every section set to input.
- R3: A control write with bit 7 = 1 and bits 6, 5 and 2 all 0 is a mode word. Bit 4 = 1 makes port A an input, bit 3 = 1 makes upper port C (bits 7..4) an input, bit 1 = 1 makes port B an input, and bit 0 = 1 makes lower port C (bits 3..0) an input. A section that is an output drives its enable bits to all ones; an input section drives them to all zeros.
- R4: A control write with bit 7 = 1 and any of bits 6, 5 or 2 set is ignored: the control register, the directions and the latches are unchanged.
- R5: An accepted mode word clears the A, B and C output latches to zero.
- R6: A write to a port address loads that port's latch. The port's output value equals its latch, and the latch holds until it is written again.
- R7: Reading port A or B while it is an input returns the live pin values in the same cycle, without latching them.
- R8: A port C read returns, for each half, the latch bits if that half is an output and the pin bits if it is an input.
- R9: A control write with bit 7 = 0 is a single-bit command. Bits 3..1 give the port C bit index and bit 0 gives the new value (1 sets, 0 clears). Only that latch bit changes.
- R10: A single-bit command leaves the control register and every direction unchanged, whatever its bits 6..4 hold.
- R11: A read of the control address returns the current control register.
- R12: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. Reading a port output is a read of its latch.
- R13: A write takes effect at the first rising clock edge at which `cs_n` and `wr_n` are both low. Nothing changes before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Host data bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A per-bit output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B per-bit output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C per-bit output enables |

## Verification
A wrong control register shows up on the enable outputs one clock after the faulty write. It also shows at once on any control read, and it changes which source a port read selects. A corrupted latch appears on the port output the cycle after the write that caused it, and on the next read of that port. A command that was wrongly accepted or wrongly ignored, such as an illegal mode word or a single-bit command, is caught by comparing every port output against a model right after each bus write. Random reads with the pins changing between accesses check the per-nibble read source.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int PORT_W = 8;
    localparam int HALF_W = PORT_W / 2;
    localparam int SEL_W  = $clog2(PORT_W);
    localparam int NHALF  = PORT_W / HALF_W;

    // control word bit positions (the host software decodes these)
    localparam int CW_KIND   = 7;
    localparam int CW_A_IN   = 4;
    localparam int CW_CU_IN  = 3;
    localparam int CW_B_IN   = 1;
    localparam int CW_CL_IN  = 0;

    localparam logic [PORT_W-1:0] CTRL_RESET = 8'h9B;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_t;

    typedef struct packed {
        logic [PORT_W-1:0] ctrl;
        logic [PORT_W-1:0] lat_a;
        logic [PORT_W-1:0] lat_b;
        logic [PORT_W-1:0] lat_c;
    } port_state_t;

    function automatic dir_t ctrl_to_dir(input logic [PORT_W-1:0] cw);
        dir_t d;
        d.a_in  = cw[CW_A_IN];
        d.cu_in = cw[CW_CU_IN];
        d.b_in  = cw[CW_B_IN];
        d.cl_in = cw[CW_CL_IN];
        return d;
    endfunction
endpackage

// File: rtl/ppi_bus_decode.sv
module ppi_bus_decode
    import ppi_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    input  logic       kind_bit,
    input  logic [2:0] mode_fields,
    output logic       wr_a,
    output logic       wr_b,
    output logic       wr_c,
    output logic       wr_mode,
    output logic       wr_bit,
    output logic       rd_en
);
    logic     wr_sel;
    reg_sel_e sel;

    always_comb begin
        sel     = reg_sel_e'(addr);
        wr_sel  = ~cs_n & ~wr_n;
        rd_en   = ~cs_n & ~rd_n;
        wr_a    = wr_sel && (sel == SEL_A);
        wr_b    = wr_sel && (sel == SEL_B);
        wr_c    = wr_sel && (sel == SEL_C);
        // mode word accepted only when every mode-select field is zero
        wr_mode = wr_sel && (sel == SEL_CTRL) && kind_bit && (mode_fields == 3'b000);
        wr_bit  = wr_sel && (sel == SEL_CTRL) && !kind_bit;
    end
endmodule

// File: rtl/ppi_port_regs.sv
module ppi_port_regs
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_c,
    input  logic              wr_mode,
    input  logic              wr_bit,
    input  logic [PORT_W-1:0] wdata,
    output port_state_t       st_o
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_a) st_d.lat_a = wdata;
        if (wr_b) st_d.lat_b = wdata;
        if (wr_c) st_d.lat_c = wdata;
        if (wr_mode) begin
            st_d.ctrl  = wdata;
            st_d.lat_a = '0;
            st_d.lat_b = '0;
            st_d.lat_c = '0;
        end
        if (wr_bit) begin
            st_d.lat_c[wdata[SEL_W:1]] = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ctrl: CTRL_RESET, lat_a: '0, lat_b: '0, lat_c: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/ppi_port_dir.sv
module ppi_port_dir
    import ppi_pkg::*;
(
    input  dir_t              dir,
    output logic [PORT_W-1:0] pa_oe,
    output logic [PORT_W-1:0] pb_oe,
    output logic [PORT_W-1:0] pc_oe
);
    logic [NHALF-1:0] c_in;

    assign c_in  = {dir.cu_in, dir.cl_in};
    assign pa_oe = {PORT_W{~dir.a_in}};
    assign pb_oe = {PORT_W{~dir.b_in}};

    for (genvar h = 0; h < NHALF; h++) begin : g_chalf
        assign pc_oe[h*HALF_W +: HALF_W] = {HALF_W{~c_in[h]}};
    end
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
    import ppi_pkg::*;
(
    input  logic [1:0]        addr,
    input  port_state_t       st,
    input  dir_t              dir,
    input  logic [PORT_W-1:0] pa_in,
    input  logic [PORT_W-1:0] pb_in,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] rdata
);
    logic [NHALF-1:0]  c_in;
    logic [PORT_W-1:0] a_val, b_val, c_val;

    assign c_in  = {dir.cu_in, dir.cl_in};
    assign a_val = dir.a_in ? pa_in : st.lat_a;
    assign b_val = dir.b_in ? pb_in : st.lat_b;

    for (genvar h = 0; h < NHALF; h++) begin : g_crd
        assign c_val[h*HALF_W +: HALF_W] = c_in[h] ? pc_in[h*HALF_W +: HALF_W]
                                                   : st.lat_c[h*HALF_W +: HALF_W];
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_A:    rdata = a_val;
            SEL_B:    rdata = b_val;
            SEL_C:    rdata = c_val;
            SEL_CTRL: rdata = st.ctrl;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppi_port_top.sv
module ppi_port_top
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              dout_oe,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    logic        wr_a, wr_b, wr_c, wr_mode, wr_bit, rd_en;
    port_state_t st;
    dir_t        dir;

    ppi_bus_decode u_dec (
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .addr        (addr),
        .kind_bit    (din[CW_KIND]),
        .mode_fields ({din[6:5], din[2]}),
        .wr_a        (wr_a),
        .wr_b        (wr_b),
        .wr_c        (wr_c),
        .wr_mode     (wr_mode),
        .wr_bit      (wr_bit),
        .rd_en       (rd_en)
    );

    ppi_port_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_c    (wr_c),
        .wr_mode (wr_mode),
        .wr_bit  (wr_bit),
        .wdata   (din),
        .st_o    (st)
    );

    assign dir = ctrl_to_dir(st.ctrl);

    ppi_port_dir u_dir (
        .dir   (dir),
        .pa_oe (pa_oe),
        .pb_oe (pb_oe),
        .pc_oe (pc_oe)
    );

    ppi_read_mux u_rmux (
        .addr  (addr),
        .st    (st),
        .dir   (dir),
        .pa_in (pa_in),
        .pb_in (pb_in),
        .pc_in (pc_in),
        .rdata (dout)
    );

    assign dout_oe = rd_en;
    assign pa_out  = st.lat_a;
    assign pb_out  = st.lat_b;
    assign pc_out  = st.lat_c;
endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       dout_oe,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    logic any_wr, ctrl_wr, mode_ok, mode_bad, bit_cmd;
    assign any_wr   = !cs_n && !wr_n;
    assign ctrl_wr  = any_wr && (addr == 2'b11);
    assign mode_ok  = ctrl_wr && din[7] && (din[6:5] == 2'b00) && !din[2];
    assign mode_bad = ctrl_wr && din[7] && !mode_ok;
    assign bit_cmd  = ctrl_wr && !din[7];

    assert_reset_inputs_R2: assert property (@(posedge clk)
        $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                        pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    assert_no_cs_no_drive_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_oe);

    assert_dirs_only_by_mode_R10: assert property (@(posedge clk) disable iff (rst)
        !mode_ok |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    assert_bad_mode_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        mode_bad |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    assert_mode_clears_R5: assert property (@(posedge clk) disable iff (rst)
        mode_ok |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    assert_bit_cmd_one_bit_R9: assert property (@(posedge clk) disable iff (rst)
        bit_cmd |=> ($countones(pc_out ^ $past(pc_out)) <= 1 &&
                     $stable(pa_out) && $stable(pb_out)));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !any_wr |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    assert_read_out_latch_R12: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && addr == 2'b00 && pa_oe == 8'hFF) |-> (dout == pa_out));

    assert_enable_shape_R3: assert property (@(posedge clk) disable iff (rst)
        ((pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF)));
endmodule

bind ppi_port_top ppi_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out),
    .pb_oe   (pb_oe),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe)
);

// File: tb/sim_ppi_port_top.sv
`timescale 1ns/1ps
module sim_ppi_port_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [7:0] m_ctrl, m_a, m_b, m_c;

    always #4 clk = ~clk;

    ppi_port_top u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] oe_of(input logic in_bit);
        return in_bit ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_c_oe();
        return {(m_ctrl[3] ? 4'h0 : 4'hF), (m_ctrl[0] ? 4'h0 : 4'hF)};
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        logic [7:0] r;
        case (a)
            2'b00: r = m_ctrl[4] ? pa_in : m_a;
            2'b01: r = m_ctrl[1] ? pb_in : m_b;
            2'b10: r = {(m_ctrl[3] ? pc_in[7:4] : m_c[7:4]),
                        (m_ctrl[0] ? pc_in[3:0] : m_c[3:0])};
            default: r = m_ctrl;
        endcase
        return r;
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'b00: m_a = d;
            2'b01: m_b = d;
            2'b10: m_c = d;
            default: begin
                if (d[7]) begin
                    if (d[6:5] == 2'b00 && !d[2]) begin
                        m_ctrl = d; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
                    end
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [1:0] a, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        check({tag, " data"}, dout, exp_read(a));
        check({tag, " oe"}, {7'd0, dout_oe}, 8'h01);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic check_pins(input string tag);
        #1;
        check({tag, " pa_out"}, pa_out, m_a);
        check({tag, " pb_out"}, pb_out, m_b);
        check({tag, " pc_out"}, pc_out, m_c);
        check({tag, " pa_oe"},  pa_oe,  oe_of(m_ctrl[4]));
        check({tag, " pb_oe"},  pb_oe,  oe_of(m_ctrl[1]));
        check({tag, " pc_oe"},  pc_oe,  exp_c_oe());
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctrl = 8'h9B; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
        repeat (3) @(negedge clk);
        // R2: state during reset
        check_pins("R2 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_pins("R2 after reset");
        bus_read(2'b11, "R2 R11 ctrl reset");

        // R12 / R1: read strobe without chip select
        @(negedge clk);
        rd_n = 1'b0; #1;
        check("R12 no cs no oe", {7'd0, dout_oe}, 8'h00);
        rd_n = 1'b1;

        // R3: all outputs
        bus_write(2'b11, 8'h80);
        check_pins("R3 all out");
        // R1: write with cs_n high has no effect
        @(negedge clk);
        wr_n = 1'b0; addr = 2'b00; din = 8'hEE;
        @(negedge clk);
        wr_n = 1'b1;
        check_pins("R1 cs high write");

        // R6, R1 decode
        bus_write(2'b00, 8'h5A);
        bus_write(2'b01, 8'hC3);
        bus_write(2'b10, 8'h7E);
        check_pins("R6 R1 port writes");
        bus_read(2'b00, "R12 read out A");

        // R13: nothing changes before the capturing edge
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'b00; din = 8'h11;
        #1;
        check("R13 before edge", pa_out, 8'h5A);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(2'b00, 8'h11);
        check_pins("R13 after edge");

        // R5, R3, R8: upper C input
        bus_write(2'b11, 8'h88);
        check_pins("R5 R3 mode clears");
        bus_write(2'b10, 8'hA5);
        pc_in = 8'h3C;
        bus_read(2'b10, "R8 mixed C");
        check("R8 mixed C value", exp_read(2'b10), 8'h35);

        // R4: illegal mode words ignored
        bus_write(2'b11, 8'hA0);
        bus_write(2'b11, 8'hC4);
        bus_write(2'b11, 8'h84);
        check_pins("R4 illegal ignored");
        bus_read(2'b11, "R4 R11 ctrl kept");

        // R9, R10: single-bit commands
        bus_write(2'b11, 8'h0F);
        check_pins("R9 set bit7");
        bus_write(2'b11, 8'h74);
        check_pins("R9 R10 clear bit2 junk high bits");
        check("R9 c latch", pc_out, 8'hA1);
        bus_read(2'b11, "R10 ctrl after bit cmd");

        // R7: live input read on A and B
        bus_write(2'b11, 8'h92);
        pa_in = 8'h69; pb_in = 8'h96;
        bus_read(2'b00, "R7 A input");
        pa_in = 8'h17;
        bus_read(2'b00, "R7 A input changed");
        bus_read(2'b01, "R7 B input");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            d  = 8'($urandom);
            case (op)
                0: bus_write(2'($urandom_range(0, 2)), d);
                1: bus_write(2'b11, {1'b1, 2'b00, d[4:3], 1'b0, d[1:0]});
                2: bus_write(2'b11, d);
                3: begin
                    pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
                end
                default: bus_read(2'($urandom_range(0, 3)), "R7 R8 R11 random read");
            endcase
            check_pins("R3 R6 R9 random pins");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule